// File: doc/BRIEF.md
# Banked General Register File

This block holds the sixteen 32-bit general registers of a processor core. The low eight architectural registers (R0 to R7) are stored twice, once per bank. The high eight (R8 to R15) are stored once and shared by both banks, so the block holds 24 physical words in total. Two combinational read ports and one clocked write port serve normal instruction traffic. They reach the low registers of the *active* bank only.

The active bank is a combinational decision. In privileged mode the bank-select input picks the bank. Outside privileged mode bank 0 is always active. A separate alternate-bank port carries a 3-bit index, a write enable and write data. It reads and writes the low registers of the bank that is *not* active, which is how control-transfer instructions save and restore the other bank. A dedicated output always shows R0 of the active bank, for use as the index operand of indexed addressing. The block has no sequencing state. Its two "states" are the active-bank values BANK_0 and BANK_1, and it moves between them only when `priv_mode` or `bank_sel` changes.

Top module: `banked_gpr_file`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all 24 physical words. Afterwards every normal read and every alternate-bank read returns 0.
- R2: R8 to R15 (index values 8 to 15) have one copy. A value written to one of them reads back the same under every combination of `priv_mode` and `bank_sel`.
- R3: With `priv_mode`=1, normal reads and writes of index 0 to 7 use bank 1 when `bank_sel`=1 and bank 0 when `bank_sel`=0.
- R4: With `priv_mode`=0, normal reads and writes of index 0 to 7 use bank 0, whatever the value of `bank_sel`.
- R5: The alternate-bank port, with index `alt_idx` (0 to 7), reads and writes that register of the bank that is not active. The normal ports never reach that bank, and the alternate port never reaches the active bank or R8 to R15.
- R6: `index_r0` always equals R0 of the active bank.
- R7: Reads are combinational. A write on either write path becomes visible only after the next rising edge, and until then the old value is read.
- R8: A change of `priv_mode` or `bank_sel` changes the read results in the same cycle. No stored word is copied or altered by the change, so switching back returns the earlier values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| priv_mode | input | 1 | 1 = privileged mode |
| bank_sel | input | 1 | Bank-select bit from the status register |
| rd_a_idx | input | 4 | Read port A register index (0 to 15) |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B register index (0 to 15) |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Normal write enable |
| wr_idx | input | 4 | Normal write register index |
| wr_data | input | 32 | Normal write data |
| alt_idx | input | 3 | Alternate-bank register index (0 to 7) |
| alt_we | input | 1 | Alternate-bank write enable |
| alt_wdata | input | 32 | Alternate-bank write data |
| alt_rdata | output | 32 | Alternate-bank read data |
| index_r0 | output | 32 | R0 of the active bank |

## Verification
The assertions check on every cycle that a normal or alternate write lands in the word it addressed and that the alternate port and the normal ports always resolve to different banks. They also check that user mode never maps a low index onto bank 1 and that `index_r0` agrees with a normal read of index 0. Only the bench scenarios can show other behaviours: that reset clears the whole array, that switching banks moves no data, that a write is invisible until the edge, and that the shared registers look the same in every mode. These scenarios compare every output with a reference model of the 24 words.

// File: rtl/bgf_pkg.sv
package bgf_pkg;

    // Which copy of the low registers normal accesses see.
    typedef enum logic {
        BANK_0 = 1'b0,
        BANK_1 = 1'b1
    } bank_e;

    // Outside privileged mode the select bit is ignored.
    function automatic bank_e active_bank(input logic priv, input logic sel);
        return (priv && sel) ? BANK_1 : BANK_0;
    endfunction

    function automatic bank_e other_bank(input bank_e b);
        return (b == BANK_1) ? BANK_0 : BANK_1;
    endfunction

endpackage

// File: rtl/bgf_map.sv
module bgf_map
    import bgf_pkg::*;
#(
    parameter int NUM_ARCH   = 16,
    parameter int NUM_BANKED = 8,
    localparam int IDX_W     = $clog2(NUM_ARCH),
    localparam int NUM_PHYS  = NUM_ARCH + NUM_BANKED,
    localparam int PHYS_W    = $clog2(NUM_PHYS)
) (
    input  logic [IDX_W-1:0]  arch_idx,
    input  bank_e             bank,
    output logic [PHYS_W-1:0] phys_idx
);

    // Layout: bank-0 copies at 0..NB-1, bank-1 copies at NB..2NB-1,
    // shared registers follow at 2NB.. (architectural index + NB).
    logic is_banked;

    always_comb begin
        is_banked = (int'(arch_idx) < NUM_BANKED);
        if (is_banked && bank == BANK_0) begin
            phys_idx = PHYS_W'(arch_idx);
        end else begin
            phys_idx = PHYS_W'(arch_idx) + PHYS_W'(NUM_BANKED);
        end
    end

endmodule

// File: rtl/bgf_store.sv
module bgf_store #(
    parameter int DATA_W   = 32,
    parameter int NUM_PHYS = 24,
    parameter int NUM_RD   = 4,
    localparam int PHYS_W  = $clog2(NUM_PHYS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PHYS_W-1:0] wr_phys,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              alt_we,
    input  logic [PHYS_W-1:0] alt_phys,
    input  logic [DATA_W-1:0] alt_wdata,
    input  logic [PHYS_W-1:0] rd_phys [NUM_RD],
    output logic [DATA_W-1:0] rd_data [NUM_RD]
);

    logic [DATA_W-1:0] regs_q [NUM_PHYS];

    // Normal path takes priority if both paths ever name one word.
    always_ff @(posedge clk) begin
        for (int p = 0; p < NUM_PHYS; p++) begin
            if (rst) begin
                regs_q[p] <= '0;
            end else if (wr_en && wr_phys == PHYS_W'(p)) begin
                regs_q[p] <= wr_data;
            end else if (alt_we && alt_phys == PHYS_W'(p)) begin
                regs_q[p] <= alt_wdata;
            end
        end
    end

    for (genvar k = 0; k < NUM_RD; k++) begin : g_rd
        assign rd_data[k] = regs_q[rd_phys[k]];
    end

    // R7
    normal_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> regs_q[$past(wr_phys)] == $past(wr_data));

    // R5
    alt_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (alt_we && !(wr_en && wr_phys == alt_phys))
            |=> regs_q[$past(alt_phys)] == $past(alt_wdata));

endmodule

// File: rtl/banked_gpr_file.sv
module banked_gpr_file
    import bgf_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int NUM_ARCH   = 16,
    parameter int NUM_BANKED = 8,
    localparam int IDX_W     = $clog2(NUM_ARCH),
    localparam int BIDX_W    = $clog2(NUM_BANKED),
    localparam int NUM_PHYS  = NUM_ARCH + NUM_BANKED,
    localparam int PHYS_W    = $clog2(NUM_PHYS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              priv_mode,
    input  logic              bank_sel,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BIDX_W-1:0] alt_idx,
    input  logic              alt_we,
    input  logic [DATA_W-1:0] alt_wdata,
    output logic [DATA_W-1:0] alt_rdata,
    output logic [DATA_W-1:0] index_r0
);

    // Lookup slots: 0 read A, 1 read B, 2 index R0, 3 alternate, 4 write.
    localparam int NUM_RD  = 4;
    localparam int NUM_MAP = NUM_RD + 1;
    localparam int SLOT_ALT = 3;
    localparam int SLOT_WR  = 4;

    bank_e             act_bank;
    bank_e             alt_bank;
    logic [IDX_W-1:0]  map_idx  [NUM_MAP];
    bank_e             map_bank [NUM_MAP];
    logic [PHYS_W-1:0] map_phys [NUM_MAP];
    logic [PHYS_W-1:0] rd_phys  [NUM_RD];
    logic [DATA_W-1:0] rd_data  [NUM_RD];

    always_comb begin
        act_bank = active_bank(priv_mode, bank_sel);
        alt_bank = other_bank(act_bank);
        map_idx[0]        = rd_a_idx;
        map_idx[1]        = rd_b_idx;
        map_idx[2]        = '0;
        map_idx[SLOT_ALT] = {{(IDX_W-BIDX_W){1'b0}}, alt_idx};
        map_idx[SLOT_WR]  = wr_idx;
        for (int m = 0; m < NUM_MAP; m++) begin
            map_bank[m] = (m == SLOT_ALT) ? alt_bank : act_bank;
        end
    end

    for (genvar m = 0; m < NUM_MAP; m++) begin : g_map
        bgf_map #(
            .NUM_ARCH   (NUM_ARCH),
            .NUM_BANKED (NUM_BANKED)
        ) u_map (
            .arch_idx (map_idx[m]),
            .bank     (map_bank[m]),
            .phys_idx (map_phys[m])
        );
    end

    for (genvar k = 0; k < NUM_RD; k++) begin : g_rdp
        assign rd_phys[k] = map_phys[k];
    end

    bgf_store #(
        .DATA_W   (DATA_W),
        .NUM_PHYS (NUM_PHYS),
        .NUM_RD   (NUM_RD)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_phys   (map_phys[SLOT_WR]),
        .wr_data   (wr_data),
        .alt_we    (alt_we),
        .alt_phys  (map_phys[SLOT_ALT]),
        .alt_wdata (alt_wdata),
        .rd_phys   (rd_phys),
        .rd_data   (rd_data)
    );

    assign rd_a_data = rd_data[0];
    assign rd_b_data = rd_data[1];
    assign index_r0  = rd_data[2];
    assign alt_rdata = rd_data[SLOT_ALT];

    // R5
    alt_never_hits_write_chk: assert property (@(posedge clk) disable iff (rst)
        map_phys[SLOT_ALT] != map_phys[SLOT_WR]);

    // R5
    alt_only_low_words_chk: assert property (@(posedge clk) disable iff (rst)
        int'(map_phys[SLOT_ALT]) < 2 * NUM_BANKED);

    // R4
    user_mode_bank0_chk: assert property (@(posedge clk) disable iff (rst)
        (!priv_mode && int'(rd_a_idx) < NUM_BANKED)
            |-> int'(map_phys[0]) < NUM_BANKED);

    // R6
    index_matches_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_a_idx == '0) |-> index_r0 == rd_a_data);

endmodule

// File: tb/banked_gpr_file_bench.sv
module banked_gpr_file_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        priv_mode, bank_sel;
    logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
    logic [31:0] rd_a_data, rd_b_data, wr_data, alt_wdata, alt_rdata, index_r0;
    logic        wr_en, alt_we;
    logic [2:0]  alt_idx;

    logic [31:0] model [24];
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    banked_gpr_file u_banked_gpr_file (
        .clk, .rst, .priv_mode, .bank_sel,
        .rd_a_idx, .rd_a_data, .rd_b_idx, .rd_b_data,
        .wr_en, .wr_idx, .wr_data,
        .alt_idx, .alt_we, .alt_wdata, .alt_rdata, .index_r0
    );

    function automatic int sel_bank(logic p, logic s);
        return (p && s) ? 1 : 0;
    endfunction

    function automatic int norm_slot(int idx, logic p, logic s);
        if (idx < 8) return idx + 8 * sel_bank(p, s);
        return idx + 8;
    endfunction

    function automatic int alt_slot(int idx, logic p, logic s);
        return idx + 8 * (1 - sel_bank(p, s));
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Clock edge; the model follows the inputs held across it.
    task automatic step();
        @(posedge clk);
        if (rst) begin
            for (int i = 0; i < 24; i++) model[i] = '0;
        end else begin
            if (alt_we) model[alt_slot(int'(alt_idx), priv_mode, bank_sel)] = alt_wdata;
            if (wr_en)  model[norm_slot(int'(wr_idx), priv_mode, bank_sel)] = wr_data;
        end
        @(negedge clk);
    endtask

    task automatic check_outputs(string tag_a);
        #1;
        check(tag_a, rd_a_data, model[norm_slot(int'(rd_a_idx), priv_mode, bank_sel)]);
        check("R3 port B", rd_b_data, model[norm_slot(int'(rd_b_idx), priv_mode, bank_sel)]);
        check("R5 alt read", alt_rdata, model[alt_slot(int'(alt_idx), priv_mode, bank_sel)]);
        check("R6 index", index_r0, model[norm_slot(0, priv_mode, bank_sel)]);
    endtask

    task automatic write_norm(logic p, logic s, int idx, logic [31:0] d);
        priv_mode = p; bank_sel = s; wr_en = 1'b1; wr_idx = 4'(idx); wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic read_a(logic p, logic s, int idx, string tag, logic [31:0] exp);
        priv_mode = p; bank_sel = s; rd_a_idx = 4'(idx);
        #1;
        check(tag, rd_a_data, exp);
    endtask

    initial begin
        rst = 1'b1; priv_mode = 1'b0; bank_sel = 1'b0;
        rd_a_idx = '0; rd_b_idx = '0; wr_idx = '0; alt_idx = '0;
        wr_en = 1'b1; wr_data = 32'hDEAD_BEEF; alt_we = 1'b1; alt_wdata = 32'h1234_5678;
        for (int i = 0; i < 24; i++) model[i] = 32'hFFFF_FFFF;
        @(negedge clk);
        step(); step(); step();
        rst = 1'b0; wr_en = 1'b0; alt_we = 1'b0;

        // R1: whole array reads zero through every path
        priv_mode = 1'b1;
        for (int s = 0; s < 2; s++) begin
            bank_sel = s[0];
            for (int i = 0; i < 16; i++) begin
                rd_a_idx = 4'(i); #1;
                check("R1 normal", rd_a_data, 32'h0);
            end
            for (int i = 0; i < 8; i++) begin
                alt_idx = 3'(i); #1;
                check("R1 alt", alt_rdata, 32'h0);
            end
        end

        // R3 and R8: two copies of R3, switching does not move data
        write_norm(1'b1, 1'b0, 3, 32'hAAAA_0003);
        write_norm(1'b1, 1'b1, 3, 32'hBBBB_0003);
        read_a(1'b1, 1'b0, 3, "R3 bank0", 32'hAAAA_0003);
        read_a(1'b1, 1'b1, 3, "R3 bank1", 32'hBBBB_0003);
        read_a(1'b1, 1'b0, 3, "R8 switch back", 32'hAAAA_0003);
        // R4: user mode ignores bank_sel
        read_a(1'b0, 1'b1, 3, "R4 user read", 32'hAAAA_0003);
        write_norm(1'b0, 1'b1, 3, 32'hCCCC_0003);
        read_a(1'b1, 1'b1, 3, "R4 user write kept bank1", 32'hBBBB_0003);
        read_a(1'b1, 1'b0, 3, "R4 user write hit bank0", 32'hCCCC_0003);
        // R5: alternate port sees the other bank
        priv_mode = 1'b1; bank_sel = 1'b0; alt_idx = 3'd3; #1;
        check("R5 alt bank1", alt_rdata, 32'hBBBB_0003);
        alt_we = 1'b1; alt_wdata = 32'hDDDD_0003; step(); alt_we = 1'b0;
        read_a(1'b1, 1'b0, 3, "R5 active untouched", 32'hCCCC_0003);
        read_a(1'b1, 1'b1, 3, "R5 alt wrote bank1", 32'hDDDD_0003);
        // R2: shared register
        write_norm(1'b1, 1'b0, 10, 32'h5555_000A);
        read_a(1'b1, 1'b1, 10, "R2 shared priv bank1", 32'h5555_000A);
        read_a(1'b0, 1'b1, 10, "R2 shared user", 32'h5555_000A);
        // R7: write invisible before the edge
        priv_mode = 1'b1; bank_sel = 1'b1; rd_a_idx = 4'd1;
        wr_en = 1'b1; wr_idx = 4'd1; wr_data = 32'h7777_0001; #1;
        check("R7 before edge", rd_a_data, model[9]);
        step(); wr_en = 1'b0; #1;
        check("R7 after edge", rd_a_data, 32'h7777_0001);
        // R6: index output follows active bank
        write_norm(1'b1, 1'b1, 0, 32'h0B0B_0000);
        write_norm(1'b1, 1'b0, 0, 32'h0A0A_0000);
        bank_sel = 1'b1; #1;
        check("R6 index bank1", index_r0, 32'h0B0B_0000);
        priv_mode = 1'b0; #1;
        check("R6 index user", index_r0, 32'h0A0A_0000);

        // Random traffic against the model
        void'($urandom(32'd2024));
        for (int n = 0; n < 800; n++) begin
            priv_mode = 1'($urandom);
            bank_sel  = 1'($urandom);
            rd_a_idx  = 4'($urandom);
            rd_b_idx  = 4'($urandom);
            alt_idx   = 3'($urandom);
            wr_idx    = 4'($urandom);
            wr_en     = ($urandom % 2) == 0;
            alt_we    = ($urandom % 3) == 0;
            wr_data   = $urandom;
            alt_wdata = $urandom;
            check_outputs(rd_a_idx < 8 ? "R3 random banked" : "R2 random shared");
            step();
        end
        wr_en = 1'b0; alt_we = 1'b0;

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule